// File: doc/BRIEF.md
# Dual-Mode Dual-Clock FIFO with Programmable Thresholds

This block carries 36-bit words from one clock domain to another. The two clocks are unrelated. Writes happen on the write clock and reads on the read clock. The words cross through a dual-port memory. The pointers are exchanged between the domains in Gray code, through a chain of synchronizer stages.

A static mode input selects how reads behave. In standard mode, a stored word reaches the output register only when a read is requested. In fall-through mode, the oldest stored word is moved to the output by itself, and a read request removes it. Each side has a ready-style flag that changes meaning with the mode, plus an active-low threshold flag.

The two threshold offsets can be set three ways. They can come from a preset chosen at master reset, from a single parallel word on the write bus, or from a serial bit stream. A master reset empties the FIFO and takes a new configuration. A partial reset empties the FIFO and keeps the configuration it already has.

Top module: `dual_mode_fifo`

## Requirements
- R1: In standard mode (fwftMode=0), stored words do not reach rdData until a read is made. A read while emptyOrRdy=1 puts the oldest word on rdData at the next read-clock edge, and words come out in write order. In this mode emptyOrRdy=1 means at least one word is stored.
- R2: In fall-through mode (fwftMode=1), the oldest word appears on rdData without a read, and emptyOrRdy=1 marks it as valid. A read moves the next word onto rdData. rdData holds while no read is made.
- R3: fullOrRdy=1 means there is space to write. Once DEPTH words are stored, fullOrRdy=0 and a further write is dropped, so no stored word is lost or overwritten.
- R4: A read made while emptyOrRdy=0 in standard mode leaves rdData unchanged and does not move the read position.
- R5: almostEmptyN=0 exactly when the number of stored words is less than or equal to offset X.
- R6: almostFullN=0 exactly when the number of free locations is less than or equal to offset Y.
- R7: During master reset, offSel sets both X and Y from a preset: 00 gives 8, 01 gives 16, and 10 gives 64.
- R8: With offSel=11 and serialMode=0 at master reset, the first write after reset is not stored. Instead it loads X from wrData[7:0] and Y from wrData[15:8] (the low 2*log2(DEPTH) bits).
- R9: With serialMode=1 at master reset, each write-clock edge with serEnN=0 shifts serData into the offsets. Exactly 2*log2(DEPTH) bits are taken: first the MSB of Y, last the LSB of X. Bits beyond that count are ignored.
- R10: After a master reset the FIFO is empty, rdData is zero, fullOrRdy=1 and almostEmptyN=0.
- R11: A partial reset empties the FIFO and clears rdData to zero. It keeps the offsets and load method already in force and does not sample offSel again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock, independent of wrClk |
| mstRstN | input | 1 | Master reset, active low, at least four edges of each clock |
| prtRstN | input | 1 | Partial reset, active low, keeps configuration |
| fwftMode | input | 1 | Static: 1 selects fall-through reads, 0 standard reads |
| offSel | input | 2 | Offset preset code sampled at master reset; 11 selects a parallel load |
| serialMode | input | 1 | Sampled at master reset: 1 selects the serial offset load |
| serEnN | input | 1 | Serial shift enable, active low, on wrClk |
| serData | input | 1 | Serial offset bit |
| wrEn | input | 1 | Write request |
| wrData | input | 36 | Write word, also the parallel offset word |
| fullOrRdy | output | 1 | 1 when there is space to write |
| almostFullN | output | 1 | Low when free locations are at or below Y |
| rdEn | input | 1 | Read request |
| rdData | output | 36 | Output register |
| emptyOrRdy | output | 1 | Standard: data stored; fall-through: rdData valid |
| almostEmptyN | output | 1 | Low when stored words are at or below X |

## Verification
The hardest states to reach are the exact threshold edges, where a single word flips a flag. Examples are free space equal to Y after a parallel or serial load, and a store that is completely full with one more write pending. The stimulus reaches them by writing exact word counts with the read side idle. It then lets the synchronizers settle before sampling, so every flag is judged on a known occupancy. The partial reset test changes offSel just before the reset, so a wrong re-sample shows up as a moved threshold. The serial test sends extra bits past the required count, so a shifter that keeps shifting corrupts a threshold that is checked afterwards.

// File: rtl/bififo_pkg.sv
package bififo_pkg;

  localparam logic [1:0] SEL_8   = 2'b00;
  localparam logic [1:0] SEL_16  = 2'b01;
  localparam logic [1:0] SEL_64  = 2'b10;
  localparam logic [1:0] SEL_PAR = 2'b11;

  typedef struct packed {
    logic wrStb;   // store wrData at the write address (write clock)
    logic rdStb;   // load the output register from the read address (read clock)
  } strobes_t;

  function automatic int presetOffset(input logic [1:0] sel);
    case (sel)
      SEL_8:   return 8;
      SEL_16:  return 16;
      default: return 64;
    endcase
  endfunction

endpackage

// File: rtl/dmf_rst_sync.sv
module dmf_rst_sync (
  input  logic clk,
  input  logic rawN,
  output logic rstN
);
  logic [1:0] stg;

  always_ff @(posedge clk or negedge rawN) begin
    if (!rawN) stg <= '0;
    else       stg <= {stg[0], 1'b1};
  end

  assign rstN = stg[1];
endmodule

// File: rtl/dmf_gray_sync.sv
module dmf_gray_sync #(
  parameter int W      = 9,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dmf_ctrl.sv
module dmf_ctrl
  import bififo_pkg::*;
#(
  parameter int DEPTH       = 256,
  parameter int SYNC_STAGES = 2,
  localparam int AW  = $clog2(DEPTH),
  localparam int PW  = AW + 1,
  localparam int SBITS = 2 * AW,
  localparam int SCW = $clog2(SBITS + 1)
) (
  input  logic            wrClk,
  input  logic            wrRstN,
  input  logic            wrMstN,
  input  logic [1:0]      offSel,
  input  logic            serialMode,
  input  logic            serEnN,
  input  logic            serData,
  input  logic            wrEn,
  input  logic [SBITS-1:0] parWord,
  output logic            fullOrRdy,
  output logic            almostFullN,
  output logic [AW-1:0]   wrAddr,
  input  logic            rdClk,
  input  logic            rdRstN,
  input  logic            fwftMode,
  input  logic            rdEn,
  output logic            emptyOrRdy,
  output logic            almostEmptyN,
  output logic [AW-1:0]   rdAddr,
  output strobes_t        strb
);

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] fromGray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write domain ----------------
  logic [PW-1:0]  wrBin, wrGray, wrBinNext, rdGraySyn, rdBinSyn, wrCount, freeCnt;
  logic [AW-1:0]  offX, offY;
  logic           serialSel, parPending, isFull, wrStb;
  logic [SCW-1:0] serCnt;

  assign rdBinSyn    = fromGray(rdGraySyn);
  assign wrCount     = wrBin - rdBinSyn;
  assign isFull      = (wrCount == PW'(DEPTH));
  assign freeCnt     = PW'(DEPTH) - wrCount;
  assign fullOrRdy   = !isFull;
  assign almostFullN = (freeCnt > {1'b0, offY});
  assign wrStb       = wrRstN & wrEn & !isFull & !parPending;
  assign wrBinNext   = wrBin + PW'(wrStb);
  assign wrAddr      = wrBin[AW-1:0];

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else begin
      wrBin  <= wrBinNext;
      wrGray <= toGray(wrBinNext);
    end
  end

  // Offset configuration: re-sampled only while master reset is held.
  always_ff @(posedge wrClk) begin
    if (!wrMstN) begin
      serialSel  <= serialMode;
      parPending <= !serialMode && (offSel == SEL_PAR);
      serCnt     <= '0;
      offX       <= AW'(presetOffset(offSel));
      offY       <= AW'(presetOffset(offSel));
    end else if (serialSel) begin
      if (!serEnN && (serCnt < SCW'(SBITS))) begin
        {offY, offX} <= {offY[AW-2:0], offX, serData};
        serCnt       <= serCnt + 1'b1;
      end
    end else if (parPending && wrEn && wrRstN) begin
      offX       <= parWord[AW-1:0];
      offY       <= parWord[SBITS-1:AW];
      parPending <= 1'b0;
    end
  end

  dmf_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) uRdToWr (
    .clk(wrClk), .rstN(wrRstN), .d(rdGray), .q(rdGraySyn)
  );

  // ---------------- read domain ----------------
  logic [PW-1:0] rdBin, rdGray, rdBinNext, wrGraySyn, wrBinSyn, memCnt, userCnt;
  logic          outValid, ramHas, rdStb;

  assign wrBinSyn  = fromGray(wrGraySyn);
  assign memCnt    = wrBinSyn - rdBin;
  assign ramHas    = (memCnt != '0);
  assign rdStb     = rdRstN & ramHas & (fwftMode ? (!outValid | rdEn) : rdEn);
  assign rdBinNext = rdBin + PW'(rdStb);
  assign rdAddr    = rdBin[AW-1:0];

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdBin    <= '0;
      rdGray   <= '0;
      outValid <= 1'b0;
    end else begin
      rdBin  <= rdBinNext;
      rdGray <= toGray(rdBinNext);
      if (!fwftMode)  outValid <= 1'b0;
      else if (rdStb) outValid <= 1'b1;
      else if (rdEn)  outValid <= 1'b0;
    end
  end

  assign emptyOrRdy   = fwftMode ? outValid : ramHas;
  assign userCnt      = memCnt + PW'(fwftMode & outValid);
  assign almostEmptyN = (userCnt > {1'b0, offX});

  dmf_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) uWrToRd (
    .clk(rdClk), .rstN(rdRstN), .d(wrGray), .q(wrGraySyn)
  );

  assign strb = '{wrStb: wrStb, rdStb: rdStb};

  // ---------------- assertions ----------------
  assert_no_overflow_R3: assert property (@(posedge wrClk) disable iff (!wrRstN)
    wrCount <= PW'(DEPTH));

  assert_no_underflow_R4: assert property (@(posedge rdClk) disable iff (!rdRstN)
    memCnt <= PW'(DEPTH));

  assert_rd_step_R1: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (rdBin == $past(rdBin)) || (rdBin == $past(rdBin) + 1'b1));

  assert_ae_when_empty_R5: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (!fwftMode && !emptyOrRdy) |-> !almostEmptyN);

endmodule

// File: rtl/dmf_data.sv
module dmf_data
  import bififo_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  strobes_t          strb,
  input  logic [AW-1:0]     wrAddr,
  input  logic [AW-1:0]     rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strb.wrStb) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN)         rdData <= '0;
    else if (strb.rdStb) rdData <= mem[rdAddr];
  end

  assert_out_clear_R10: assert property (@(posedge rdClk)
    $rose(rdRstN) |-> (rdData == '0));

endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo
  import bififo_pkg::*;
#(
  parameter int DATA_W      = 36,
  parameter int DEPTH       = 256,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              mstRstN,
  input  logic              prtRstN,
  input  logic              fwftMode,
  input  logic [1:0]        offSel,
  input  logic              serialMode,
  input  logic              serEnN,
  input  logic              serData,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              fullOrRdy,
  output logic              almostFullN,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              emptyOrRdy,
  output logic              almostEmptyN
);
  logic          rawN, wrRstN, rdRstN, wrMstN;
  logic [AW-1:0] wrAddr, rdAddr;
  strobes_t      strb;

  assign rawN = mstRstN & prtRstN;

  dmf_rst_sync uWrRst (.clk(wrClk), .rawN(rawN),    .rstN(wrRstN));
  dmf_rst_sync uRdRst (.clk(rdClk), .rawN(rawN),    .rstN(rdRstN));
  dmf_rst_sync uWrMst (.clk(wrClk), .rawN(mstRstN), .rstN(wrMstN));

  dmf_ctrl #(.DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrMstN(wrMstN), .offSel(offSel),
    .serialMode(serialMode), .serEnN(serEnN), .serData(serData), .wrEn(wrEn),
    .parWord(wrData[2*AW-1:0]), .fullOrRdy(fullOrRdy), .almostFullN(almostFullN),
    .wrAddr(wrAddr), .rdClk(rdClk), .rdRstN(rdRstN), .fwftMode(fwftMode),
    .rdEn(rdEn), .emptyOrRdy(emptyOrRdy), .almostEmptyN(almostEmptyN),
    .rdAddr(rdAddr), .strb(strb)
  );

  dmf_data #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uData (
    .wrClk(wrClk), .rdClk(rdClk), .rdRstN(rdRstN), .strb(strb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData), .rdData(rdData)
  );

  assert_fwft_hold_R2: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (fwftMode && emptyOrRdy && !rdEn) |=> $stable(rdData));

  assert_empty_read_hold_R4: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (!fwftMode && !emptyOrRdy) |=> $stable(rdData));

endmodule

// File: tb/dual_mode_fifo_bench.sv
module dual_mode_fifo_bench;
  localparam int DEPTH = 256;

  logic        wrClk = 1'b0, rdClk = 1'b0;
  logic        mstRstN = 1'b1, prtRstN = 1'b1;
  logic        fwftMode = 1'b0, serialMode = 1'b0, serEnN = 1'b1, serData = 1'b0;
  logic [1:0]  offSel = 2'b00;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [35:0] wrData = '0;
  logic [35:0] rdData;
  logic        fullOrRdy, almostFullN, emptyOrRdy, almostEmptyN;

  int          nCmp = 0, nBad = 0, seed = 1;
  logic [35:0] q[$];
  logic [35:0] lastWord;

  always #4ns wrClk = ~wrClk;
  always #5ns rdClk = ~rdClk;

  dual_mode_fifo #(.DEPTH(DEPTH)) u_dual_mode_fifo (
    .wrClk(wrClk), .rdClk(rdClk), .mstRstN(mstRstN), .prtRstN(prtRstN),
    .fwftMode(fwftMode), .offSel(offSel), .serialMode(serialMode),
    .serEnN(serEnN), .serData(serData), .wrEn(wrEn), .wrData(wrData),
    .fullOrRdy(fullOrRdy), .almostFullN(almostFullN), .rdEn(rdEn),
    .rdData(rdData), .emptyOrRdy(emptyOrRdy), .almostEmptyN(almostEmptyN)
  );

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic settle();
    #300ns;
  endtask

  task automatic wrPush(input logic [35:0] d);
    @(negedge wrClk); wrEn = 1'b1; wrData = d;
    @(negedge wrClk); wrEn = 1'b0;
  endtask

  task automatic putN(input int n);
    for (int i = 0; i < n; i++) begin
      logic [35:0] d;
      d = {seed[3:0], 32'(seed * 32'h9E37_79B1)};
      seed++;
      wrPush(d);
      q.push_back(d);
    end
  endtask

  task automatic rdPop(input string tag);
    logic [35:0] exp;
    @(negedge rdClk); rdEn = 1'b1;
    @(negedge rdClk); rdEn = 1'b0;
    exp = q.pop_front();
    lastWord = exp;
    chk(tag, rdData, exp);
  endtask

  task automatic drain(input string tag);
    while (q.size() > 0) rdPop(tag);
    settle();
  endtask

  task automatic fwPop();
    logic [35:0] exp;
    @(negedge rdClk);
    exp = q.pop_front();
    chk("R2 valid", emptyOrRdy, 1);
    chk("R2 data", rdData, exp);
    rdEn = 1'b1;
    @(negedge rdClk); rdEn = 1'b0;
  endtask

  task automatic doMaster(input logic [1:0] sel, input logic ser, input logic fw);
    fwftMode = fw; offSel = sel; serialMode = ser;
    mstRstN = 1'b0;
    repeat (6) @(negedge wrClk);
    repeat (6) @(negedge rdClk);
    mstRstN = 1'b1;
    q.delete();
    settle();
  endtask

  task automatic doPartial();
    prtRstN = 1'b0;
    repeat (6) @(negedge wrClk);
    repeat (6) @(negedge rdClk);
    prtRstN = 1'b1;
    q.delete();
    settle();
  endtask

  task automatic serBit(input logic b);
    @(negedge wrClk); serEnN = 1'b0; serData = b;
    @(negedge wrClk); serEnN = 1'b1;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    #1ms;
    nCmp++; nBad++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    summary();
  end

  initial begin
    #1ns mstRstN = 1'b0;
    // R10: state after master reset, preset code 00 (offset 8)
    doMaster(2'b00, 1'b0, 1'b0);
    chk("R10 empty", emptyOrRdy, 0);
    chk("R10 space", fullOrRdy, 1);
    chk("R10 almostEmptyN", almostEmptyN, 0);
    chk("R10 almostFullN", almostFullN, 1);
    chk("R10 rdData zero", rdData, 36'h0);

    // R1: standard mode needs an explicit read
    putN(5); settle();
    chk("R1 data stored", emptyOrRdy, 1);
    chk("R1 no fall-through", rdData, 36'h0);
    drain("R1 order");
    chk("R1 empty after drain", emptyOrRdy, 0);

    // R4: read while empty is ignored
    @(negedge rdClk); rdEn = 1'b1;
    @(negedge rdClk); rdEn = 1'b0;
    settle();
    chk("R4 rdData held", rdData, lastWord);
    chk("R4 still empty", emptyOrRdy, 0);
    putN(1); settle();
    rdPop("R4 pointer intact");
    settle();

    // R5 / R7: offset 8
    putN(8); settle();
    chk("R5 R7 count=8", almostEmptyN, 0);
    putN(1); settle();
    chk("R5 R7 count=9", almostEmptyN, 1);
    drain("R5 data");

    // R7: offset 16, then R11 partial reset keeps it
    doMaster(2'b01, 1'b0, 1'b0);
    putN(16); settle();
    chk("R7 16 at 16", almostEmptyN, 0);
    putN(1); settle();
    chk("R7 16 at 17", almostEmptyN, 1);
    rdPop("R11 pre-read");
    offSel = 2'b10;
    doPartial();
    chk("R11 emptied", emptyOrRdy, 0);
    chk("R11 rdData zero", rdData, 36'h0);
    putN(16); settle();
    chk("R11 offset kept at 16", almostEmptyN, 0);
    putN(1); settle();
    chk("R11 offset kept at 17", almostEmptyN, 1);

    // R6 / R3: fill with Y=16
    putN(239 - 17); settle();
    chk("R6 free=17", almostFullN, 1);
    putN(1); settle();
    chk("R6 free=16", almostFullN, 0);
    putN(16); settle();
    chk("R3 full", fullOrRdy, 0);
    wrPush(36'hBAD_BAD_BAD);
    settle();
    chk("R3 still full", fullOrRdy, 0);
    drain("R3 no loss");
    chk("R3 dropped word absent", emptyOrRdy, 0);
    chk("R3 space again", fullOrRdy, 1);

    // R7: offset 64
    doMaster(2'b10, 1'b0, 1'b0);
    putN(64); settle();
    chk("R7 64 at 64", almostEmptyN, 0);
    putN(1); settle();
    chk("R7 64 at 65", almostEmptyN, 1);
    drain("R7 data");

    // R8: parallel load X=3, Y=5
    doMaster(2'b11, 1'b0, 1'b0);
    wrPush({20'h0, 8'd5, 8'd3});
    settle();
    chk("R8 load word not stored", emptyOrRdy, 0);
    putN(3); settle();
    chk("R8 X=3 at 3", almostEmptyN, 0);
    putN(1); settle();
    chk("R8 X=3 at 4", almostEmptyN, 1);
    putN(246); settle();
    chk("R8 Y=5 free=6", almostFullN, 1);
    putN(1); settle();
    chk("R8 Y=5 free=5", almostFullN, 0);
    drain("R8 data");

    // R9: serial load Y=10, X=2, then extra bits
    doMaster(2'b00, 1'b1, 1'b0);
    begin
      logic [15:0] stream;
      stream = {8'd10, 8'd2};
      for (int i = 15; i >= 0; i--) serBit(stream[i]);
      for (int i = 0; i < 3; i++) serBit(1'b1);
    end
    putN(2); settle();
    chk("R9 X=2 at 2", almostEmptyN, 0);
    putN(1); settle();
    chk("R9 X=2 at 3", almostEmptyN, 1);
    putN(242); settle();
    chk("R9 Y=10 free=11", almostFullN, 1);
    putN(1); settle();
    chk("R9 Y=10 free=10", almostFullN, 0);
    drain("R9 data");

    // R2: fall-through mode
    doMaster(2'b00, 1'b0, 1'b1);
    chk("R2 nothing valid", emptyOrRdy, 0);
    putN(1); settle();
    chk("R2 first word valid", emptyOrRdy, 1);
    chk("R2 first word shown", rdData, q[0]);
    #100ns;
    chk("R2 held without read", rdData, q[0]);
    putN(3); settle();
    for (int i = 0; i < 4; i++) fwPop();
    settle();
    chk("R2 nothing valid after reads", emptyOrRdy, 0);

    summary();
  end
endmodule